// File: doc/BRIEF.md
# Prefetch Buffer with Branch Folding

This block sits between the instruction fetch port and the integer pipeline. It owns the fetch address, takes one fetched word per cycle into a small instruction queue, and looks at each word's pre-decode tag as it arrives. Most branches are caught there, well before the pipeline asks for them. A branch predicted taken sends the fetch address straight to its target. Returns are passed through with a flag so that a later return-address predictor can act on them.

In the two execution modes that allow it, a predicted-taken branch is folded. It is never queued and uses no issue slot. The next instruction that is queued carries a marker bit so that later stages can account for the folded branch. In the remaining mode, prediction and redirection still happen, but the branch is queued and delivered like any other instruction.

When the core raises a flush (exception, abort, interrupt or mispredict), the queue is emptied and fetch restarts at the address the core supplies. The core pops one instruction per cycle whenever it is ready.

Top module: `prefetch_fold_queue`

## Requirements
- R1: After reset the queue is empty (`out_valid`=0), `fetch_ready`=1 and `fetch_addr` equals the parameter `RESET_ADDR`.
- R2: The queue holds at most `DEPTH` (default 7) instructions and delivers them in arrival order. `fetch_ready` is 0 exactly when `DEPTH` instructions are held, and a word offered then is not taken.
- R3: A word is accepted when `fetch_valid`=1, `fetch_ready`=1 and `flush`=0. It is recorded with address `fetch_addr`. If it is not predicted taken, `fetch_addr` advances by 4 on the next cycle.
- R4: Tag encoding: 0 = plain, 1 = conditional branch, 2 = unconditional branch, 3 = return. An accepted word is predicted taken when its tag is 2, or when its tag is 1 and `fetch_hint`=1. A predicted-taken word sets `fetch_addr` to `fetch_target` on the next cycle.
- R5: When `exec_mode` is 0 or 1, a predicted-taken word is folded: it is never delivered and takes no queue slot.
- R6: When `exec_mode` is 2 or 3, a predicted-taken word is queued and delivered, and it still redirects fetch.
- R7: The first word queued after one or more folds is delivered with `out_folded`=1. Every other delivered word has `out_folded`=0.
- R8: A word with tag 3 is never folded, does not redirect fetch, and is delivered with `out_ret`=1. All other words have `out_ret`=0.
- R9: `flush`=1 empties the queue, discards any pending fold marker and sets `fetch_addr` to `flush_addr` on the next cycle. It overrides any fetch or pop in the same cycle.
- R10: When `out_valid`=1 and `core_ready`=1, exactly one instruction is removed per cycle. With `core_ready`=0 the head instruction is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetched word is offered |
| fetch_instr | input | IW | Fetched instruction word |
| fetch_tag | input | 2 | Pre-decode class (0 plain, 1 cond branch, 2 uncond branch, 3 return) |
| fetch_target | input | AW | Branch target for the offered word |
| fetch_hint | input | 1 | Target cache predicts taken for a conditional branch |
| exec_mode | input | 2 | Execution mode; 0 and 1 permit folding |
| flush | input | 1 | Core flush / redirect |
| flush_addr | input | AW | Restart address for a flush |
| fetch_ready | output | 1 | Queue can take a word this cycle |
| fetch_addr | output | AW | Address of the next word to fetch |
| core_ready | input | 1 | Core takes the head instruction |
| out_valid | output | 1 | Head instruction is valid |
| out_instr | output | IW | Head instruction word |
| out_addr | output | AW | Head instruction address |
| out_ret | output | 1 | Head instruction is a return |
| out_folded | output | 1 | A branch was folded just before the head instruction |

## Verification
The properties assume that `fetch_tag`, `fetch_hint` and `fetch_target` are only meaningful together with `fetch_valid`. They also assume that the fetch side holds no word of its own across a flush: a word offered in the cycle of a flush is dropped, not replayed. The stimulus draws tags, hints, modes and readiness at random each cycle, with flushes scattered throughout. It offers words only as fresh values and never depends on a word being retried. Directed sequences add the full-queue stall, a fold in a folding mode and the same branch in a non-folding mode, so that the fold marker and the return flag are seen on known addresses.

// File: rtl/prefetch_fold_queue.sv
module prefetch_fold_queue #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DEPTH = 7,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [IW-1:0] fetch_instr,
  input  logic [1:0]    fetch_tag,
  input  logic [AW-1:0] fetch_target,
  input  logic          fetch_hint,
  input  logic [1:0]    exec_mode,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  output logic          fetch_ready,
  output logic [AW-1:0] fetch_addr,
  input  logic          core_ready,
  output logic          out_valid,
  output logic [IW-1:0] out_instr,
  output logic [AW-1:0] out_addr,
  output logic          out_ret,
  output logic          out_folded
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [IW-1:0] q_instr [DEPTH];
  logic [AW-1:0] q_addr  [DEPTH];
  logic          q_ret   [DEPTH];
  logic          q_fold  [DEPTH];

  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] pc;
  logic          fold_pend;

  wire accept     = fetch_valid && fetch_ready && !flush;
  wire pred_taken = (fetch_tag == 2'd2) || (fetch_tag == 2'd1 && fetch_hint);
  wire fold_now   = accept && pred_taken && !exec_mode[1];
  wire push       = accept && !fold_now;
  wire pop        = out_valid && core_ready && !flush;

  assign fetch_ready = (count != FULL);
  assign fetch_addr  = pc;
  assign out_valid   = (count != '0);
  assign out_instr   = q_instr[rd_ptr];
  assign out_addr    = q_addr[rd_ptr];
  assign out_ret     = q_ret[rd_ptr];
  assign out_folded  = q_fold[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      count     <= '0;
      pc        <= RESET_ADDR;
      fold_pend <= 1'b0;
    end else if (flush) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      count     <= '0;
      pc        <= flush_addr;
      fold_pend <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (accept) pc <= pred_taken ? fetch_target : pc + AW'(4);
      if (fold_now)  fold_pend <= 1'b1;
      else if (push) fold_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_instr[wr_ptr] <= fetch_instr;
      q_addr[wr_ptr]  <= pc;
      q_ret[wr_ptr]   <= (fetch_tag == 2'd3);
      q_fold[wr_ptr]  <= fold_pend;
    end
  end
endmodule

// File: rtl/prefetch_fold_checks.sv
module prefetch_fold_checks #(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic [1:0]    fetch_tag,
  input logic [AW-1:0] fetch_target,
  input logic          fetch_hint,
  input logic          flush,
  input logic [AW-1:0] flush_addr,
  input logic          fetch_ready,
  input logic [AW-1:0] fetch_addr,
  input logic          core_ready,
  input logic          out_valid,
  input logic [IW-1:0] out_instr,
  input logic          out_ret
);
  wire acc   = fetch_valid && fetch_ready && !flush;
  wire taken = (fetch_tag == 2'd2) || (fetch_tag == 2'd1 && fetch_hint);

  assert_full_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ready |-> out_valid);

  assert_seq_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !taken |=> fetch_addr == $past(fetch_addr) + AW'(4));

  assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && taken |=> fetch_addr == $past(fetch_target));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && fetch_addr == $past(flush_addr));

  assert_hold_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !core_ready && !flush |=> out_valid && $stable(out_instr) && $stable(out_ret));
endmodule

bind prefetch_fold_queue prefetch_fold_checks #(.AW(AW), .IW(IW)) u_checks (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_tag(fetch_tag),
  .fetch_target(fetch_target), .fetch_hint(fetch_hint), .flush(flush),
  .flush_addr(flush_addr), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
  .core_ready(core_ready), .out_valid(out_valid), .out_instr(out_instr),
  .out_ret(out_ret)
);

// File: tb/tb_prefetch_fold_queue.sv
module tb_prefetch_fold_queue;
  localparam int AW = 32;
  localparam int IW = 32;
  localparam int DEPTH = 7;
  localparam logic [AW-1:0] RST = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, fetch_hint = 0, flush = 0, core_ready = 0;
  logic [IW-1:0] fetch_instr = '0;
  logic [1:0] fetch_tag = '0, exec_mode = '0;
  logic [AW-1:0] fetch_target = '0, flush_addr = '0;
  logic fetch_ready, out_valid, out_ret, out_folded;
  logic [AW-1:0] fetch_addr, out_addr;
  logic [IW-1:0] out_instr;

  always #4 clk = ~clk;

  prefetch_fold_queue #(.AW(AW), .IW(IW), .DEPTH(DEPTH), .RESET_ADDR(RST)) dut (.*);

  typedef struct { logic [IW-1:0] instr; logic [AW-1:0] addr; bit ret; bit fold; } ent_t;
  ent_t mq[$];
  logic [AW-1:0] m_pc;
  bit m_pend, m_acc, m_taken;
  int m_sz;
  int checks = 0, failures = 0, cycles = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_pc = RST; m_pend = 0;
    end else if (flush) begin
      mq.delete(); m_pc = flush_addr; m_pend = 0;
    end else begin
      m_sz = mq.size();
      m_acc = fetch_valid && (m_sz < DEPTH);
      if (m_sz > 0 && core_ready) void'(mq.pop_front());
      if (m_acc) begin
        m_taken = (fetch_tag == 2) || (fetch_tag == 1 && fetch_hint);
        if (m_taken && exec_mode < 2) begin
          m_pend = 1; m_pc = fetch_target;
        end else begin
          mq.push_back('{fetch_instr, m_pc, fetch_tag == 3, m_pend});
          m_pend = 0;
          m_pc = m_taken ? fetch_target : m_pc + 4;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare();
    bit ev = mq.size() > 0;
    chk(fetch_ready === (mq.size() < DEPTH), "R2 fetch_ready", 64'(fetch_ready), 64'(mq.size() < DEPTH));
    chk(fetch_addr === m_pc, "R3 R4 R9 fetch_addr", 64'(fetch_addr), 64'(m_pc));
    chk(out_valid === ev, "R10 out_valid", 64'(out_valid), 64'(ev));
    if (ev) begin
      chk(out_instr === mq[0].instr, "R2 out_instr order", 64'(out_instr), 64'(mq[0].instr));
      chk(out_addr === mq[0].addr, "R5 R6 out_addr", 64'(out_addr), 64'(mq[0].addr));
      chk(out_ret === mq[0].ret, "R8 out_ret", 64'(out_ret), 64'(mq[0].ret));
      chk(out_folded === mq[0].fold, "R7 out_folded", 64'(out_folded), 64'(mq[0].fold));
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); cycles++; compare();
  endtask

  task automatic offer(input logic [1:0] tag, input logic [IW-1:0] w, input logic [AW-1:0] tgt, input bit hint);
    fetch_valid = 1; fetch_tag = tag; fetch_instr = w; fetch_target = tgt; fetch_hint = hint;
    step();
    fetch_valid = 0;
  endtask

  task automatic do_flush(input logic [AW-1:0] a);
    flush = 1; flush_addr = a; step(); flush = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();
    chk(out_valid === 0 && fetch_ready === 1 && fetch_addr === RST, "R1 reset state",
        {fetch_addr, 30'b0, out_valid, fetch_ready}, {RST, 30'b0, 1'b0, 1'b1});

    core_ready = 1;
    for (int i = 0; i < 10; i++) offer(2'd0, 32'hA000_0000 + i, '0, 0);
    repeat (3) step();

    core_ready = 0;
    for (int i = 0; i < 10; i++) offer(2'd0, 32'hB000_0000 + i, '0, 0);
    chk(fetch_ready === 0, "R2 full stall", 64'(fetch_ready), 64'(0));
    core_ready = 1;
    repeat (9) step();
    chk(out_valid === 0, "R10 drained", 64'(out_valid), 64'(0));

    do_flush(32'h100);
    core_ready = 0; exec_mode = 2'd0;
    offer(2'd0, 32'hC1, '0, 0);
    offer(2'd2, 32'hC2, 32'h400, 0);
    offer(2'd3, 32'hC3, '0, 0);
    chk(out_addr === 32'h100 && out_folded === 0, "R5 head before fold", 64'(out_addr), 64'(32'h100));
    core_ready = 1; step(); core_ready = 0;
    chk(out_addr === 32'h400 && out_folded === 1, "R7 fold marker after fold", 64'({out_folded, out_addr}), 64'({1'b1, 32'h400}));
    chk(out_ret === 1, "R8 return flagged", 64'(out_ret), 64'(1));
    chk(fetch_addr === 32'h404, "R8 return no redirect", 64'(fetch_addr), 64'(32'h404));

    do_flush(32'h200);
    exec_mode = 2'd2;
    offer(2'd0, 32'hD1, '0, 0);
    offer(2'd1, 32'hD2, 32'h800, 1);
    offer(2'd0, 32'hD3, '0, 0);
    core_ready = 1; step(); core_ready = 0;
    chk(out_addr === 32'h204 && out_instr === 32'hD2 && out_folded === 0, "R6 branch delivered unfolded",
        64'(out_addr), 64'(32'h204));
    do_flush(32'h300);
    chk(out_valid === 0 && fetch_addr === 32'h300, "R9 flush empties", 64'(out_valid), 64'(0));

    for (int i = 0; i < 4000; i++) begin
      fetch_valid = ($urandom_range(0, 3) != 0);
      fetch_tag = 2'($urandom_range(0, 3));
      fetch_hint = 1'($urandom_range(0, 1));
      fetch_instr = $urandom;
      fetch_target = {$urandom_range(0, 16'hFFFF), 2'b00};
      core_ready = ($urandom_range(0, 2) != 0);
      if (i % 200 == 0) exec_mode = 2'($urandom_range(0, 3));
      flush = ($urandom_range(0, 39) == 0);
      flush_addr = {$urandom_range(0, 16'hFFFF), 2'b00};
      step();
    end
    flush = 0; fetch_valid = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule